// File: doc/BRIEF.md
# JESD204B Transmit Link Start-Up Controller

This block governs the link-establishment sequence on the transmit side of one JESD204B lane group. It keeps a local frame phase and a local multiframe phase, and it keeps both aligned to the SYSREF reference. It watches the receiver's active-low synchronization request and decides, one cycle at a time, what class of symbol the lanes carry. The classes are an idle alternating pattern, K28.5 comma characters, the initial lane alignment (ILA) sequence, and converter data. The 8b/10b encoder and the serializer sit downstream and use the selector and the ILA multiframe index to build the octets. Those octets are outside this block.

SYSREF passes through an enable gate and then two registers. The controller compares each rising edge with its own phase counters. An edge that falls on a multiframe boundary is accepted silently. An edge that falls on a frame boundary inside a multiframe leaves the phases unchanged. An edge that falls inside a frame forces both counters onto the new phase and restarts the link. A restart passes through a model serializer-PLL settling wait of configurable length, then sends K28.5, and then enters the ILA on its own at the next multiframe boundary unless the receiver holds a request. Two sticky, write-one-to-clear status flags record SYSREF activity and realignment for software.

Top module: `jesd_tx_link_ctrl`

## Requirements
- R1: `lane_sel` encodes 0 = alternating 0101 pattern, 1 = K28.5, 2 = ILA, 3 = data. When `link_en` is low, or `cal_done` is low, `lane_sel` is 0 from the following cycle.
- R2: When the link starts after calibration, or after a realignment, `lane_sel` shows K28.5. This covers a wait of `PLL_CAL_CYCLES` cycles and then code-group synchronization. With no request held, the ILA begins at the first multiframe boundary after the wait ends. The ILA is entered only from K28.5.
- R3: The ILA lasts exactly 4 multiframes. During the ILA, `ila_mf_idx` counts 0 to 3, one step per multiframe. Data follows at once, and `link_up` is 1 only while data is sent.
- R4: `k_minus1` holds K−1. The multiframe lasts K frames of `FRAME_CYCLES` clocks each. Values below 8 act as 8, so K is never less than 9.
- R5: A low on `syncn_in` that spans fewer than 4 frame ends is ignored, and a running link stays up.
- R6: A low on `syncn_in` that spans 4 frame ends is an accepted request. The link breaks at once, K28.5 is sent, and `sync_ok` is 0 until `syncn_in` returns high. The ILA then starts on a multiframe boundary, and the multiframe phase is unchanged.
- R7: A gated SYSREF edge that lands on a multiframe boundary sets `align_flag` and changes nothing else.
- R8: A gated SYSREF edge that lands on a frame boundary but not on a multiframe boundary sets `align_flag`. `realign_flag` stays 0 and the link is not disturbed.
- R9: A gated SYSREF edge that lands inside a frame makes that detection cycle phase 0 of both the frame and the multiframe. It sets `align_flag` and `realign_flag` and restarts the link as in R2. The detection cycle is the cycle after the first clock edge that samples the gated input high.
- R10: While `sysref_gate_en` is low, SYSREF edges have no effect.
- R11: `align_clr` and `realign_clr` clear their flags one cycle later. If a flag is set and cleared in the same cycle, the set wins.
- R12: While `cal_done` is low, SYSREF is not processed and both flags read 0 from the following cycle.
- R13: While reset is asserted, `lane_sel` = 0, `ila_mf_idx` = 0, `link_up` = 0, `sync_ok` = 1, and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sysref_in | input | 1 | SYSREF reference, synchronous to clk |
| sysref_gate_en | input | 1 | Lets SYSREF reach the phase logic |
| syncn_in | input | 1 | Receiver synchronization request, active low |
| k_minus1 | input | 5 | Frames per multiframe minus one |
| cal_done | input | 1 | Converter calibrated and clocks ready |
| link_en | input | 1 | Enables link symbols; low selects the alternating pattern |
| align_clr | input | 1 | Clears align_flag (write-one-to-clear) |
| realign_clr | input | 1 | Clears realign_flag (write-one-to-clear) |
| lane_sel | output | 2 | Lane symbol class selector |
| ila_mf_idx | output | 2 | ILA multiframe index, 0 outside the ILA |
| link_up | output | 1 | Data transmission in progress |
| sync_ok | output | 1 | No accepted synchronization request pending |
| align_flag | output | 1 | A SYSREF edge was processed |
| realign_flag | output | 1 | A SYSREF edge realigned the clocks |

## Verification
A processed SYSREF edge and a software clear can arrive in the same cycle, and both act on the same sticky status flag. The bench fires an aligned SYSREF edge and drives `align_clr` high so that it is sampled at the clock edge that registers the detection. The flag must read 1 in the next cycle, so the set wins. In a separate step the bench shows that a lone clear pulse, with no edge, clears the flag.

// File: rtl/jtl_pkg.sv
package jtl_pkg;
  typedef enum logic [1:0] {
    SEL_ALT   = 2'd0,
    SEL_KCHAR = 2'd1,
    SEL_ILA   = 2'd2,
    SEL_DATA  = 2'd3
  } lane_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PLLCAL,
    ST_CGS,
    ST_ILA,
    ST_DATA
  } link_st_e;

  typedef enum logic [1:0] {
    SR_NONE,
    SR_MATCH,
    SR_LMFC_ONLY,
    SR_FRAME
  } sr_class_e;
endpackage

// File: rtl/jtl_phase_ctr.sv
// Local frame and multiframe phase counters with realignment load.
module jtl_phase_ctr #(
  parameter int FRAME_CYCLES = 2,
  parameter int KW           = 5,
  parameter int K_MIN_M1     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          realign,
  input  logic [KW-1:0] k_m1,
  output logic          frame_last,
  output logic          mf_last,
  output logic          frame_zero,
  output logic          lmfc_zero
);
  localparam int FW = (FRAME_CYCLES > 1) ? $clog2(FRAME_CYCLES) : 1;

  logic [KW-1:0] k_eff;
  logic [KW-1:0] lcnt_q, lcnt_d;

  assign k_eff = (k_m1 < KW'(K_MIN_M1)) ? KW'(K_MIN_M1) : k_m1;

  generate
    if (FRAME_CYCLES == 1) begin : g_single
      assign frame_last = 1'b1;
      assign frame_zero = 1'b1;
    end else begin : g_multi
      logic [FW-1:0] fcnt_q, fcnt_d;
      // The detection cycle is phase 0, so the following cycle is phase 1.
      always_comb begin
        if (realign)                              fcnt_d = FW'(1);
        else if (fcnt_q == FW'(FRAME_CYCLES - 1)) fcnt_d = '0;
        else                                      fcnt_d = fcnt_q + FW'(1);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fcnt_q <= '0;
        else        fcnt_q <= fcnt_d;
      end
      assign frame_last = (fcnt_q == FW'(FRAME_CYCLES - 1));
      assign frame_zero = (fcnt_q == '0);
    end
  endgenerate

  always_comb begin
    if (realign)         lcnt_d = (FRAME_CYCLES == 1) ? KW'(1) : '0;
    else if (frame_last) lcnt_d = (lcnt_q >= k_eff) ? '0 : lcnt_q + KW'(1);
    else                 lcnt_d = lcnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lcnt_q <= '0;
    else        lcnt_q <= lcnt_d;
  end

  assign mf_last   = frame_last && (lcnt_q >= k_eff);
  assign lmfc_zero = (lcnt_q == '0);
endmodule

// File: rtl/jtl_sysref_eval.sv
// Gates, registers and classifies SYSREF rising edges against the local phase.
module jtl_sysref_eval
  import jtl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sysref_in,
  input  logic      gate_en,
  input  logic      active,
  input  logic      frame_zero,
  input  logic      lmfc_zero,
  output sr_class_e sr_class,
  output logic      realign
);
  logic sr_q1, sr_q2, sr_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q1 <= 1'b0;
      sr_q2 <= 1'b0;
    end else begin
      sr_q1 <= sysref_in & gate_en;
      sr_q2 <= sr_q1;
    end
  end

  assign sr_edge = sr_q1 & ~sr_q2 & active;

  always_comb begin
    if (!sr_edge)                     sr_class = SR_NONE;
    else if (frame_zero && lmfc_zero) sr_class = SR_MATCH;
    else if (frame_zero)              sr_class = SR_LMFC_ONLY;
    else                              sr_class = SR_FRAME;
  end

  assign realign = (sr_class == SR_FRAME);
endmodule

// File: rtl/jtl_sync_filt.sv
// Qualifies the active-low synchronization request by counting frame ends.
module jtl_sync_filt #(
  parameter int MIN_FRAMES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic syncn_in,
  input  logic frame_last,
  output logic sync_req
);
  localparam int CW = $clog2(MIN_FRAMES + 1);

  logic          syncn_q;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (syncn_q)                                      cnt_d = '0;
    else if (frame_last && cnt_q != CW'(MIN_FRAMES))  cnt_d = cnt_q + CW'(1);
    else                                              cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncn_q <= 1'b1;
      cnt_q   <= '0;
    end else begin
      syncn_q <= syncn_in;
      cnt_q   <= cnt_d;
    end
  end

  assign sync_req = (cnt_q == CW'(MIN_FRAMES));
endmodule

// File: rtl/jtl_seq.sv
// Link sequencing: PLL wait, code-group sync, ILA multiframes, data.
module jtl_seq
  import jtl_pkg::*;
#(
  parameter int PLL_CAL_CYCLES = 16,
  parameter int ILA_MFRAMES    = 4,
  parameter int IW             = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          realign,
  input  logic          sync_req,
  input  logic          mf_last,
  output link_st_e      state_o,
  output logic [IW-1:0] idx_o
);
  localparam int PW = $clog2(PLL_CAL_CYCLES + 1);

  link_st_e      st_q, st_d;
  logic [PW-1:0] pll_q, pll_d;
  logic [IW-1:0] idx_q, idx_d;

  always_comb begin
    st_d  = st_q;
    pll_d = pll_q;
    idx_d = idx_q;
    if (!run) begin
      st_d  = ST_IDLE;
      pll_d = '0;
      idx_d = '0;
    end else if (realign) begin
      st_d  = ST_PLLCAL;
      pll_d = '0;
      idx_d = '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          st_d  = ST_PLLCAL;
          pll_d = '0;
        end
        ST_PLLCAL: begin
          if (pll_q == PW'(PLL_CAL_CYCLES - 1)) st_d  = ST_CGS;
          else                                  pll_d = pll_q + PW'(1);
        end
        ST_CGS: begin
          if (mf_last && !sync_req) begin
            st_d  = ST_ILA;
            idx_d = '0;
          end
        end
        ST_ILA: begin
          if (sync_req) st_d = ST_CGS;
          else if (mf_last) begin
            if (idx_q == IW'(ILA_MFRAMES - 1)) st_d  = ST_DATA;
            else                               idx_d = idx_q + IW'(1);
          end
        end
        ST_DATA: begin
          if (sync_req) st_d = ST_CGS;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      pll_q <= '0;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      pll_q <= pll_d;
      idx_q <= idx_d;
    end
  end

  assign state_o = st_q;
  assign idx_o   = idx_q;
endmodule

// File: rtl/jesd_tx_link_ctrl.sv
module jesd_tx_link_ctrl
  import jtl_pkg::*;
#(
  parameter int FRAME_CYCLES    = 2,
  parameter int PLL_CAL_CYCLES  = 16,
  parameter int SYNC_MIN_FRAMES = 4,
  parameter int ILA_MFRAMES     = 4,
  parameter int KW              = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sysref_in,
  input  logic          sysref_gate_en,
  input  logic          syncn_in,
  input  logic [KW-1:0] k_minus1,
  input  logic          cal_done,
  input  logic          link_en,
  input  logic          align_clr,
  input  logic          realign_clr,
  output logic [1:0]    lane_sel,
  output logic [1:0]    ila_mf_idx,
  output logic          link_up,
  output logic          sync_ok,
  output logic          align_flag,
  output logic          realign_flag
);
  localparam int IW = (ILA_MFRAMES > 1) ? $clog2(ILA_MFRAMES) : 1;

  logic [1:0]    rs_q;
  logic          rst_int_n;
  logic          frame_last, mf_last, frame_zero, lmfc_zero;
  logic          realign, sync_req, run;
  logic          align_d, realign_d;
  sr_class_e     sr_class;
  link_st_e      state;
  logic [IW-1:0] idx;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  assign run = cal_done & link_en;

  jtl_phase_ctr #(.FRAME_CYCLES(FRAME_CYCLES), .KW(KW), .K_MIN_M1(8)) u_phase (
    .clk(clk), .rst_n(rst_int_n), .realign(realign), .k_m1(k_minus1),
    .frame_last(frame_last), .mf_last(mf_last),
    .frame_zero(frame_zero), .lmfc_zero(lmfc_zero)
  );

  jtl_sysref_eval u_sref (
    .clk(clk), .rst_n(rst_int_n), .sysref_in(sysref_in), .gate_en(sysref_gate_en),
    .active(cal_done), .frame_zero(frame_zero), .lmfc_zero(lmfc_zero),
    .sr_class(sr_class), .realign(realign)
  );

  jtl_sync_filt #(.MIN_FRAMES(SYNC_MIN_FRAMES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .syncn_in(syncn_in),
    .frame_last(frame_last), .sync_req(sync_req)
  );

  jtl_seq #(.PLL_CAL_CYCLES(PLL_CAL_CYCLES), .ILA_MFRAMES(ILA_MFRAMES), .IW(IW)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .run(run), .realign(realign),
    .sync_req(sync_req), .mf_last(mf_last), .state_o(state), .idx_o(idx)
  );

  // Sticky flags: set beats clear; clock loss clears.
  always_comb begin
    align_d   = align_flag;
    realign_d = realign_flag;
    if (!cal_done) begin
      align_d   = 1'b0;
      realign_d = 1'b0;
    end else begin
      if (sr_class != SR_NONE) align_d = 1'b1;
      else if (align_clr)      align_d = 1'b0;
      if (realign)             realign_d = 1'b1;
      else if (realign_clr)    realign_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      align_flag   <= 1'b0;
      realign_flag <= 1'b0;
    end else begin
      align_flag   <= align_d;
      realign_flag <= realign_d;
    end
  end

  always_comb begin
    unique case (state)
      ST_PLLCAL, ST_CGS: lane_sel = SEL_KCHAR;
      ST_ILA:            lane_sel = SEL_ILA;
      ST_DATA:           lane_sel = SEL_DATA;
      default:           lane_sel = SEL_ALT;
    endcase
  end

  assign ila_mf_idx = (state == ST_ILA) ? 2'(idx) : 2'd0;
  assign link_up    = (state == ST_DATA);
  assign sync_ok    = ~sync_req;
endmodule

// File: rtl/jtl_checker.sv
module jtl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       link_en,
  input logic       cal_done,
  input logic [1:0] lane_sel,
  input logic [1:0] ila_mf_idx,
  input logic       link_up,
  input logic       sync_ok,
  input logic       align_flag,
  input logic       realign_flag
);
  assert_alt_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !link_en |=> lane_sel == 2'd0);

  assert_ila_from_kchar_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_sel == 2'd2 && $past(lane_sel) != 2'd2) |-> $past(lane_sel) == 2'd1);

  assert_ila_idx_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_sel == 2'd2 && $past(lane_sel) == 2'd2) |->
      (ila_mf_idx == $past(ila_mf_idx) || ila_mf_idx == $past(ila_mf_idx) + 2'd1));

  assert_data_after_ila_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up && !$past(link_up)) |-> ($past(lane_sel) == 2'd2 && $past(ila_mf_idx) == 2'd3));

  assert_request_drops_link_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_ok |=> !link_up);

  assert_realign_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(realign_flag) |-> lane_sel != 2'd3);

  assert_flags_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_done |=> (!align_flag && !realign_flag));
endmodule

bind jesd_tx_link_ctrl jtl_checker u_chk (
  .clk(clk), .rst_n(rst_n), .link_en(link_en), .cal_done(cal_done),
  .lane_sel(lane_sel), .ila_mf_idx(ila_mf_idx), .link_up(link_up),
  .sync_ok(sync_ok), .align_flag(align_flag), .realign_flag(realign_flag)
);

// File: tb/jesd_tx_link_ctrl_tb.sv
`timescale 1ns/1ps
module jesd_tx_link_ctrl_tb;
  localparam int PLL   = 16;
  localparam int WDOG  = 150000;
  // {k_minus1, ILA start offset from realign detection, ILA length}
  localparam int VEC [6][3] = '{
    '{3, 18, 72}, '{8, 18, 72}, '{9, 20, 80},
    '{15, 32, 128}, '{31, 64, 256}, '{11, 24, 96}
  };

  logic clk = 1'b0;
  logic rst_n, sysref_in, gate_en, syncn_in, cal_done, link_en, align_clr, realign_clr;
  logic [4:0] k_minus1;
  logic [1:0] lane_sel, ila_mf_idx;
  logic link_up, sync_ok, align_flag, realign_flag;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int rf;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  jesd_tx_link_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sysref_in(sysref_in), .sysref_gate_en(gate_en),
    .syncn_in(syncn_in), .k_minus1(k_minus1), .cal_done(cal_done), .link_en(link_en),
    .align_clr(align_clr), .realign_clr(realign_clr), .lane_sel(lane_sel),
    .ila_mf_idx(ila_mf_idx), .link_up(link_up), .sync_ok(sync_ok),
    .align_flag(align_flag), .realign_flag(realign_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (cyc == WDOG) begin
      n_fail++;
      $display("FAIL R2 watchdog: actual %0d cycles expected fewer", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  task automatic fire(input int c);
    while (cyc < c - 1) @(negedge clk);
    sysref_in = 1'b1;
    @(negedge clk);
    sysref_in = 1'b0;
  endtask

  function automatic int next_at(input int base, input int mf, input int off);
    int c = base + off;
    while (c < cyc + 3) c += mf;
    return c;
  endfunction

  task automatic wait_sel(input logic [1:0] s, output int at);
    int n = 0;
    while (lane_sel != s && n < 3000) begin
      @(negedge clk);
      n++;
    end
    at = (lane_sel == s) ? cyc : -1;
  endtask

  // Measures one ILA: start phase, per-multiframe index, length, data entry.
  task automatic run_ila(input int base, input int mf, input int exp_start, input int exp_len,
                         input string req);
    int s, e, n;
    bit idx_ok = 1'b1;
    wait_sel(2'd2, s);
    if (exp_start >= 0) chk(s - base == exp_start, req, s - base, exp_start);
    else                chk(s >= 0 && (s - base) % mf == 0, req, (s - base) % mf, 0);
    n = 0;
    while (lane_sel == 2'd2 && n < 3000) begin
      if (ila_mf_idx != 2'((s < 0 ? 0 : cyc - s) / mf)) idx_ok = 1'b0;
      @(negedge clk);
      n++;
    end
    e = cyc;
    chk(idx_ok, "R3 ila index", int'(idx_ok), 1);
    chk(lane_sel == 2'd3 && e - s == exp_len, "R3 ila length", e - s, exp_len);
    chk(link_up == 1'b1, "R3 link_up in data", int'(link_up), 1);
  endtask

  task automatic hold_up(input int n, input string req);
    bit ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!link_up || lane_sel != 2'd3) ok = 1'b0;
    end
    chk(ok, req, int'(ok), 1);
  endtask

  task automatic pulse_clr;
    align_clr = 1'b1;
    realign_clr = 1'b1;
    @(negedge clk);
    align_clr = 1'b0;
    realign_clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int c, t;
    rst_n = 1'b0; sysref_in = 1'b0; gate_en = 1'b1; syncn_in = 1'b1;
    cal_done = 1'b1; link_en = 1'b1; align_clr = 1'b0; realign_clr = 1'b0;
    k_minus1 = 5'd11;
    repeat (3) @(negedge clk);
    // R13 reset values
    chk(lane_sel == 2'd0 && ila_mf_idx == 2'd0, "R13 reset lane_sel/idx", lane_sel, 0);
    chk(!link_up && sync_ok && !align_flag && !realign_flag, "R13 reset status",
        {link_up, sync_ok, align_flag, realign_flag}, 4'b0100);

    // Vector table: per K, force a realignment and time the ILA (R2, R3, R4, R9)
    for (int v = 0; v < 6; v++) begin
      rst_n = 1'b0;
      k_minus1 = 5'(VEC[v][0]);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      t = cyc + 3;
      fire(t);
      fire(t + 3);
      rf = t + 3;
      run_ila(rf, VEC[v][1] * 4 / VEC[v][2] * 0 + VEC[v][2] / 4, VEC[v][1], VEC[v][2],
              "R2 R4 ila start after realign");
    end

    // Directed tests, K = 12, multiframe = 24 clocks
    chk(sync_ok && lane_sel == 2'd3, "R3 steady data", lane_sel, 3);

    // R5: short request ignored
    syncn_in = 1'b0;
    repeat (6) @(negedge clk);
    syncn_in = 1'b1;
    hold_up(20, "R5 short sync low ignored");

    // R6: long request breaks link
    syncn_in = 1'b0;
    repeat (12) @(negedge clk);
    chk(lane_sel == 2'd1 && !link_up, "R6 link broken to K28.5", lane_sel, 1);
    chk(sync_ok == 1'b0, "R6 sync_ok low", int'(sync_ok), 0);
    syncn_in = 1'b1;
    run_ila(rf, 24, -1, 96, "R6 ila on multiframe boundary");

    // R11: plain clear
    pulse_clr;
    chk(!align_flag && !realign_flag, "R11 clear", {align_flag, realign_flag}, 0);

    // R7: aligned edge
    c = next_at(rf, 24, 0);
    fire(c);
    @(negedge clk);
    chk(align_flag && !realign_flag, "R7 aligned edge flags", {align_flag, realign_flag}, 2);
    hold_up(30, "R7 aligned edge leaves link");

    // R8: frame-aligned, multiframe-misaligned edge
    pulse_clr;
    c = next_at(rf, 24, 6);
    fire(c);
    @(negedge clk);
    chk(align_flag && !realign_flag, "R8 lmfc-only flags", {align_flag, realign_flag}, 2);
    hold_up(60, "R8 lmfc-only leaves link");

    // R10: gate closed, misaligned edge
    pulse_clr;
    gate_en = 1'b0;
    c = next_at(rf, 24, 5);
    fire(c);
    @(negedge clk);
    chk(!align_flag && !realign_flag, "R10 gated edge ignored", {align_flag, realign_flag}, 0);
    hold_up(30, "R10 gated edge leaves link");
    gate_en = 1'b1;

    // R11: set and clear in the same cycle
    c = next_at(rf, 24, 0);
    fire(c);
    align_clr = 1'b1;
    @(negedge clk);
    align_clr = 1'b0;
    chk(align_flag == 1'b1, "R11 set wins over clear", int'(align_flag), 1);

    // R9: frame-misaligned edge realigns and restarts
    pulse_clr;
    c = next_at(rf, 24, 7);
    fire(c);
    @(negedge clk);
    chk(realign_flag && align_flag, "R9 realign flags", {align_flag, realign_flag}, 3);
    chk(lane_sel == 2'd1, "R9 restart to K28.5", lane_sel, 1);
    rf = c;
    run_ila(rf, 24, 24, 96, "R9 ila from new phase");

    // R1: link disabled
    link_en = 1'b0;
    @(negedge clk);
    chk(lane_sel == 2'd0 && !link_up, "R1 alt pattern when disabled", lane_sel, 0);
    link_en = 1'b1;
    run_ila(rf, 24, -1, 96, "R2 restart after enable");

    // R12: calibration lost
    cal_done = 1'b0;
    @(negedge clk);
    chk(!align_flag && !realign_flag && lane_sel == 2'd0, "R12 cal lost",
        {align_flag, realign_flag, lane_sel}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule